// File: doc/BRIEF.md
# Character-Synchronous Serial Transceiver

This block sends and receives characters on a synchronous serial line. One bit moves on each cycle in which the bit-enable strobe is high. The host writes characters into a one-deep holding register. At every character boundary the transmitter takes the waiting character. If no character is waiting, it sends a programmed sync character instead, so the line never goes idle. Characters are 5 to 8 data bits long, sent least significant bit first, with an optional parity bit after the data.

The receiver starts out hunting. With internal sync, it compares the last frame's worth of received bits against the first sync frame on every bit. In double-sync mode it then also requires the second sync frame on the very next character boundary. With external sync, a pulse on the sync input fixes the boundary instead.

Once locked, the receiver cuts the bit stream into characters. It reports each character with ready, parity-error and overrun flags. A host hunt command drops lock and restarts the search.

Top module: `sync_char_xcvr`

## Requirements
- R1: After reset: `tx_ser`=1, `tx_ready`=1, `tx_empty`=1, `rx_ready`=0, `rx_sync_det`=0, `rx_par_err`=0 and `rx_overrun`=0.
- R2: Character length is `cfg_len`+5 data bits (code 0 gives 5 bits, code 3 gives 8). Each frame is the data bits, least significant first, followed by one parity bit when `cfg_par_en`=1. `tx_ser` changes only in cycles where `bit_en`=1, one bit per such cycle.
- R3: A `tx_wr` pulse is accepted only while `tx_ready`=1, and `tx_ready` then drops in the next cycle. A write while `tx_ready`=0 is ignored. The held character is sent as the next frame that starts at a character boundary, and `tx_ready` returns to 1 at that boundary.
- R4: When no character is held at a boundary, the transmitter sends a fill frame. In single-sync mode every fill frame is `sync1`. In double-sync mode the fill frames alternate `sync1`, `sync2`, `sync1`, … starting with `sync1` after any data frame. `tx_empty` is 1 while a fill frame is being sent and 0 while a data frame is being sent.
- R5: In internal hunt, when the received bits that complete a frame equal the `sync1` frame (same length and parity settings), lock is taken at that bit. In single-sync mode `rx_sync_det` rises at that bit.
- R6: In double-sync mode, after `sync1` is matched, the next full frame must equal the `sync2` frame. If it does, `rx_sync_det` rises. If it does not, the receiver goes back to hunting and `rx_sync_det` stays 0.
- R7: With `cfg_ext_sync`=1, a hunting receiver locks on the bit strobe where `ext_sync_in`=1. That bit is discarded, and the next bit is data bit 0. The internal pattern is ignored in this mode.
- R8: While locked, each completed frame puts its data bits, zero-extended to 8 bits, on `rx_data` and sets `rx_ready`. `rx_rd` clears `rx_ready`.
- R9: With parity enabled, the parity bit is even parity when `cfg_par_odd`=0 and odd parity when `cfg_par_odd`=1. `rx_par_err` shows whether the character on `rx_data` arrived with a wrong parity bit.
- R10: A character that completes while `rx_ready`=1, with no `rx_rd` in that cycle, overwrites `rx_data` and sets `rx_overrun`. `rx_rd` clears `rx_overrun`.
- R11: `hunt_cmd` clears `rx_sync_det` and returns the receiver to hunting. A new sync pattern is then needed before it locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-bit strobe for both directions |
| cfg_len | input | 2 | Data length code, length = code + 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| cfg_dual_sync | input | 1 | Two-character sync pattern |
| cfg_ext_sync | input | 1 | Receiver locks on `ext_sync_in` instead of the pattern |
| sync1 | input | 8 | First sync character |
| sync2 | input | 8 | Second sync character |
| tx_wr | input | 1 | Host write strobe |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Fill frame in progress |
| tx_ser | output | 1 | Serial output |
| rx_ser | input | 1 | Serial input |
| ext_sync_in | input | 1 | External boundary marker |
| hunt_cmd | input | 1 | Drop lock and hunt |
| rx_rd | input | 1 | Host read strobe |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Received character waiting |
| rx_sync_det | output | 1 | Receiver locked |
| rx_par_err | output | 1 | Parity error on `rx_data` |
| rx_overrun | output | 1 | A character was overwritten |

## Verification
The bench drives the receiver at every data length, with both parity senses and both sync depths. If the design sliced the sliding window at the wrong offset, it would lock one bit early or late and deliver shifted characters. A double-sync pattern whose second half is wrong must leave the receiver unlocked; a design that locked on the first half alone would report sync there.

A write made while the holding register is full must not reach the line, and fill frames must alternate in the right order after a data frame. External-sync mode must ignore a perfect internal pattern and must discard the marker bit; an off-by-one there shifts every received character. Two characters with no read in between must raise overrun and keep the newer one.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    localparam int CHAR_MAX = 8;
    localparam int FRAME_W  = CHAR_MAX + 1;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int LEN_BASE = 5;

    typedef logic [CHAR_MAX-1:0] char_t;
    typedef logic [FRAME_W-1:0]  frame_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       dual_sync;
    } link_cfg_t;

    typedef enum logic [1:0] {
        PH_HUNT   = 2'd0,
        PH_SECOND = 2'd1,
        PH_LOCKED = 2'd2
    } rx_phase_e;

    // Number of data bits for a length code.
    function automatic cnt_t data_bits(logic [1:0] code);
        return cnt_t'(code) + cnt_t'(LEN_BASE);
    endfunction

    // Data bits plus the parity bit when enabled.
    function automatic cnt_t frame_bits(link_cfg_t c);
        return data_bits(c.len_code) + cnt_t'(c.par_en);
    endfunction

    function automatic char_t len_mask(logic [1:0] code);
        char_t m;
        for (int i = 0; i < CHAR_MAX; i++) begin
            m[i] = (i < int'(data_bits(code)));
        end
        return m;
    endfunction

    function automatic logic parity_of(char_t d, link_cfg_t c);
        return (^(d & len_mask(c.len_code))) ^ c.par_odd;
    endfunction

    // Frame, LSB transmitted first, parity just above the data.
    function automatic frame_t build_frame(char_t d, link_cfg_t c);
        frame_t f;
        f = {1'b0, d & len_mask(c.len_code)};
        if (c.par_en) begin
            f[data_bits(c.len_code)] = parity_of(d, c);
        end
        return f;
    endfunction

    // The newest frame_bits() bits of a window filled from the top.
    function automatic frame_t align_window(frame_t w, link_cfg_t c);
        return w >> (cnt_t'(FRAME_W) - frame_bits(c));
    endfunction

endpackage

// File: rtl/sxc_tx.sv
module sxc_tx
    import sxc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  link_cfg_t cfg,
    input  char_t     sync1,
    input  char_t     sync2,
    input  logic      wr,
    input  char_t     wdata,
    output logic      ready,
    output logic      empty,
    output logic      ser
);

    logic   hold_v;
    char_t  hold_d;
    frame_t shreg;
    cnt_t   left;
    logic   ser_q;
    logic   fill_q;
    logic   second_q;

    char_t  next_char;
    logic   next_fill;
    frame_t next_frame;
    logic   boundary;

    always_comb begin
        if (hold_v) begin
            next_char = hold_d;
            next_fill = 1'b0;
        end else begin
            next_char = (cfg.dual_sync && second_q) ? sync2 : sync1;
            next_fill = 1'b1;
        end
        next_frame = build_frame(next_char, cfg);
        boundary   = bit_en && (left == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_d   <= '0;
            shreg    <= '0;
            left     <= '0;
            ser_q    <= 1'b1;
            fill_q   <= 1'b1;
            second_q <= 1'b0;
        end else begin
            if (boundary) begin
                ser_q    <= next_frame[0];
                shreg    <= next_frame >> 1;
                left     <= frame_bits(cfg) - cnt_t'(1);
                fill_q   <= next_fill;
                second_q <= next_fill ? !second_q : 1'b0;
                if (hold_v) begin
                    hold_v <= 1'b0;
                end
            end else if (bit_en) begin
                ser_q <= shreg[0];
                shreg <= shreg >> 1;
                left  <= left - cnt_t'(1);
            end
            if (wr && !hold_v) begin
                hold_v <= 1'b1;
                hold_d <= wdata;
            end
        end
    end

    assign ready = !hold_v;
    assign empty = fill_q;
    assign ser   = ser_q;

endmodule

// File: rtl/sxc_rx.sv
module sxc_rx
    import sxc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  link_cfg_t cfg,
    input  logic      ext_mode,
    input  char_t     sync1,
    input  char_t     sync2,
    input  logic      ser,
    input  logic      ext_sync,
    input  logic      hunt,
    input  logic      rd,
    output char_t     data,
    output logic      ready,
    output logic      sync_det,
    output logic      par_err,
    output logic      overrun
);

    rx_phase_e phase;
    frame_t    win;
    cnt_t      cnt;

    frame_t win_n;
    frame_t aligned;
    logic   last_bit;
    logic   match1;
    logic   match2;
    char_t  got_data;
    logic   got_bad;

    always_comb begin
        win_n    = {ser, win[FRAME_W-1:1]};
        aligned  = align_window(win_n, cfg);
        last_bit = (cnt == frame_bits(cfg) - cnt_t'(1));
        match1   = (aligned == build_frame(sync1, cfg));
        match2   = (aligned == build_frame(sync2, cfg));
        got_data = aligned[CHAR_MAX-1:0] & len_mask(cfg.len_code);
        got_bad  = cfg.par_en &&
                   (aligned[data_bits(cfg.len_code)] != parity_of(got_data, cfg));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_HUNT;
            win      <= '1;
            cnt      <= '0;
            data     <= '0;
            ready    <= 1'b0;
            sync_det <= 1'b0;
            par_err  <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (rd) begin
                ready   <= 1'b0;
                overrun <= 1'b0;
            end
            if (hunt) begin
                phase    <= PH_HUNT;
                win      <= '1;
                cnt      <= '0;
                sync_det <= 1'b0;
            end else if (bit_en) begin
                win <= win_n;
                case (phase)
                    PH_HUNT: begin
                        if (ext_mode) begin
                            if (ext_sync) begin
                                phase    <= PH_LOCKED;
                                cnt      <= '0;
                                sync_det <= 1'b1;
                            end
                        end else if (match1) begin
                            cnt <= '0;
                            if (cfg.dual_sync) begin
                                phase <= PH_SECOND;
                            end else begin
                                phase    <= PH_LOCKED;
                                sync_det <= 1'b1;
                            end
                        end
                    end
                    PH_SECOND: begin
                        if (last_bit) begin
                            cnt <= '0;
                            if (match2) begin
                                phase    <= PH_LOCKED;
                                sync_det <= 1'b1;
                            end else begin
                                phase <= PH_HUNT;
                            end
                        end else begin
                            cnt <= cnt + cnt_t'(1);
                        end
                    end
                    PH_LOCKED: begin
                        if (last_bit) begin
                            cnt     <= '0;
                            data    <= got_data;
                            par_err <= got_bad;
                            ready   <= 1'b1;
                            if (ready && !rd) begin
                                overrun <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + cnt_t'(1);
                        end
                    end
                    default: phase <= PH_HUNT;
                endcase
            end
        end
    end

endmodule

// File: rtl/sync_char_xcvr.sv
module sync_char_xcvr
    import sxc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_dual_sync,
    input  logic       cfg_ext_sync,
    input  logic [7:0] sync1,
    input  logic [7:0] sync2,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_empty,
    output logic       tx_ser,
    input  logic       rx_ser,
    input  logic       ext_sync_in,
    input  logic       hunt_cmd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       rx_sync_det,
    output logic       rx_par_err,
    output logic       rx_overrun
);

    link_cfg_t cfg;

    always_comb begin
        cfg.len_code  = cfg_len;
        cfg.par_en    = cfg_par_en;
        cfg.par_odd   = cfg_par_odd;
        cfg.dual_sync = cfg_dual_sync;
    end

    sxc_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .bit_en(bit_en),
        .cfg   (cfg),
        .sync1 (sync1),
        .sync2 (sync2),
        .wr    (tx_wr),
        .wdata (tx_data),
        .ready (tx_ready),
        .empty (tx_empty),
        .ser   (tx_ser)
    );

    sxc_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .cfg     (cfg),
        .ext_mode(cfg_ext_sync),
        .sync1   (sync1),
        .sync2   (sync2),
        .ser     (rx_ser),
        .ext_sync(ext_sync_in),
        .hunt    (hunt_cmd),
        .rd      (rx_rd),
        .data    (rx_data),
        .ready   (rx_ready),
        .sync_det(rx_sync_det),
        .par_err (rx_par_err),
        .overrun (rx_overrun)
    );

endmodule

// File: rtl/sxc_checker.sv
module sxc_checker (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic tx_wr,
    input logic tx_ready,
    input logic tx_ser,
    input logic hunt_cmd,
    input logic rx_ready,
    input logic rx_sync_det,
    input logic rx_overrun
);

    assert_write_takes_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_ready) |=> !tx_ready);

    assert_line_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_ser));

    assert_lock_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_sync_det) |-> $past(bit_en));

    assert_char_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(bit_en));

    assert_overrun_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_ready));

    assert_hunt_drops_lock_R11: assert property (@(posedge clk) disable iff (rst)
        hunt_cmd |=> !rx_sync_det);

endmodule

bind sync_char_xcvr sxc_checker u_sxc_checker (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .tx_wr      (tx_wr),
    .tx_ready   (tx_ready),
    .tx_ser     (tx_ser),
    .hunt_cmd   (hunt_cmd),
    .rx_ready   (rx_ready),
    .rx_sync_det(rx_sync_det),
    .rx_overrun (rx_overrun)
);

// File: tb/sync_char_xcvr_test.sv
module sync_char_xcvr_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_dual_sync = 1'b0;
    logic       cfg_ext_sync = 1'b0;
    logic [7:0] sync1 = 8'h16;
    logic [7:0] sync2 = 8'h2B;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, tx_empty, tx_ser;
    logic       rx_ser = 1'b1;
    logic       ext_sync_in = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_sync_det, rx_par_err, rx_overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sync_char_xcvr uut (.*);

    // [15:14] length code, [13] parity on, [12] odd, [11] dual sync,
    // [10] corrupt parity, [7:0] data
    localparam logic [15:0] RXV [6] = '{
        16'hC0A5, 16'h2013, 16'hB85A, 16'hEC3C, 16'h742E, 16'hC800
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] bframe(input logic [7:0] d, input int n,
                                          input logic pe, input logic po, input logic flip);
        logic [8:0] f = '0;
        logic p = po;
        for (int i = 0; i < n; i++) begin
            f[i] = d[i];
            p ^= d[i];
        end
        if (pe) f[n] = p ^ flip;
        return f;
    endfunction

    task automatic send_bit(input logic b);
        rx_ser = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip);
        int n = int'(cfg_len) + 5;
        logic [8:0] f = bframe(d, n, cfg_par_en, cfg_par_odd, flip);
        for (int i = 0; i < n + int'(cfg_par_en); i++) send_bit(f[i]);
    endtask

    task automatic pulse_hunt();
        hunt_cmd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        hunt_cmd = 1'b0;
    endtask

    task automatic pulse_read();
        rx_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic do_reset();
        bit_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Writes d with the line stalled, then captures nfr frames.
    task automatic tx_run(input logic [7:0] d, input int nfr, input string tag);
        int n = int'(cfg_len) + 5;
        int fl = n + int'(cfg_par_en);
        logic [8:0] expf [4];
        logic [8:0] got;
        expf[0] = bframe(d, n, cfg_par_en, cfg_par_odd, 1'b0);
        for (int k = 1; k < 4; k++) begin
            expf[k] = bframe((cfg_dual_sync && (k % 2 == 0)) ? sync2 : sync1,
                             n, cfg_par_en, cfg_par_odd, 1'b0);
        end
        tx_wr = 1'b1; tx_data = d;
        @(posedge clk); @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_ready == 1'b0, {"R3 ready drops ", tag}, tx_ready, 0);
        tx_wr = 1'b1; tx_data = ~d;          // ignored: register full
        @(posedge clk); @(negedge clk);
        tx_wr = 1'b0;
        chk(tx_ser == 1'b1, {"R2 line held without strobe ", tag}, tx_ser, 1);
        bit_en = 1'b1;
        for (int f = 0; f < nfr; f++) begin
            got = '0;
            for (int b = 0; b < fl; b++) begin
                @(posedge clk); @(negedge clk);
                got[b] = tx_ser;
                if (b == 0) begin
                    chk(tx_empty == (f != 0), {"R4 empty flag ", tag}, tx_empty, (f != 0));
                    if (f == 0) chk(tx_ready == 1'b1, {"R3 ready after load ", tag}, tx_ready, 1);
                end
            end
            chk(got == expf[f], (f == 0) ? {"R3 R2 data frame ", tag} : {"R4 fill frame ", tag},
                got, expf[f]);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(tx_ser == 1 && tx_ready == 1 && tx_empty == 1, "R1 tx reset",
            {tx_ser, tx_ready, tx_empty}, 3'b111);
        chk(rx_ready == 0 && rx_sync_det == 0 && rx_par_err == 0 && rx_overrun == 0,
            "R1 rx reset", {rx_ready, rx_sync_det, rx_par_err, rx_overrun}, 0);

        // Transmitter: 8 bits even parity single sync
        cfg_len = 2'd3; cfg_par_en = 1; cfg_par_odd = 0; cfg_dual_sync = 0;
        tx_run(8'hC3, 3, "single");
        // Transmitter: 6 bits, no parity, double sync
        do_reset();
        cfg_len = 2'd1; cfg_par_en = 0; cfg_dual_sync = 1;
        tx_run(8'h2A, 4, "dual");

        // Receiver vector walk
        bit_en = 1'b1;
        for (int v = 0; v < 6; v++) begin
            logic [15:0] e = RXV[v];
            cfg_len = e[15:14]; cfg_par_en = e[13]; cfg_par_odd = e[12];
            cfg_dual_sync = e[11]; cfg_ext_sync = 0;
            pulse_hunt();
            chk(rx_sync_det == 0, "R11 hunt clears lock", rx_sync_det, 0);
            repeat (3) send_bit(1'b1);
            send_frame(sync1, 1'b0);
            if (e[11]) begin
                chk(rx_sync_det == 0, "R6 first half only", rx_sync_det, 0);
                send_frame(sync2, 1'b0);
            end
            chk(rx_sync_det == 1, "R5 R6 lock on pattern", rx_sync_det, 1);
            send_frame(e[7:0], e[10]);
            chk(rx_ready == 1 && rx_data == e[7:0], "R8 received char",
                rx_data, e[7:0]);
            chk(rx_par_err == e[10], "R9 parity flag", rx_par_err, e[10]);
            pulse_read();
            chk(rx_ready == 0, "R8 read clears ready", rx_ready, 0);
        end

        // R6 broken second half
        cfg_len = 2'd3; cfg_par_en = 0; cfg_dual_sync = 1;
        pulse_hunt();
        repeat (3) send_bit(1'b1);
        send_frame(sync1, 1'b0);
        send_frame(8'hFF, 1'b0);
        chk(rx_sync_det == 0, "R6 wrong second char", rx_sync_det, 0);
        send_frame(sync1, 1'b0);
        send_frame(sync2, 1'b0);
        chk(rx_sync_det == 1, "R6 relock", rx_sync_det, 1);

        // R10 overrun
        send_frame(8'h11, 1'b0);
        send_frame(8'h22, 1'b0);
        chk(rx_overrun == 1 && rx_data == 8'h22, "R10 overrun newer kept",
            {rx_overrun, rx_data}, {1'b1, 8'h22});
        pulse_read();
        chk(rx_overrun == 0 && rx_ready == 0, "R10 read clears", {rx_overrun, rx_ready}, 0);

        // R7 external sync
        cfg_ext_sync = 1; cfg_dual_sync = 0;
        pulse_hunt();
        repeat (3) send_bit(1'b1);
        send_frame(sync1, 1'b0);
        chk(rx_sync_det == 0, "R7 pattern ignored", rx_sync_det, 0);
        ext_sync_in = 1'b1;
        send_bit(1'b0);
        ext_sync_in = 1'b0;
        chk(rx_sync_det == 1, "R7 external lock", rx_sync_det, 1);
        send_frame(8'h6D, 1'b0);
        chk(rx_ready == 1 && rx_data == 8'h6D, "R7 marker bit discarded", rx_data, 8'h6D);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule